// File: doc/BRIEF.md
# Cascaded Set/Reset Sequence Recognizer

The block classifies a stream of one-bit symbols, taking one symbol per clock while `sym_valid_i` is high. Its state is a chain of `NUM_FF` set/reset flip-flops. Each stage has its own set and clear terms, and those terms depend on only two things: the current symbol and the state of the stages below it. Because of this one-way dependency, the machine can only recognise counter-free languages. A parity check, for example, is out of its reach.

The language is fixed at elaboration by `LANG`, and the accepting set of state vectors is fixed by `ACC`. The supported languages are:
- at least k ones seen;
- a trailing run of ones;
- a trailing run of zeros;
- an alternating 0,1,0,... pattern seen as a subsequence.

The `state_o` vector is visible at the port, so that a neighbour can decode prefixes of a language as well as the final verdict. With `NUM_FF=2`, the at-least language gives "two or more ones seen". With `NUM_FF=1`, the zero-run language gives "the last symbol was 0".

Top module: `rsr_recognizer`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `state_o` equals the parameter `INIT`, and `accept_o` is the decode of `INIT`.
- R2: On a rising edge with `sym_valid_i`=1, a stage whose set term is 1 becomes 1, a stage whose clear term is 1 becomes 0, and a stage with neither term active keeps its value. The result appears on `state_o` after that edge.
- R3: A stage's set and clear terms are never both 1 in a valid cycle.
- R4: The terms of stage j (`state_o` bit j) use only `sym_i` and the pre-edge values of bits below j. Bit j>0 can rise only if bit j-1 was 1 before the edge. Bit 0 depends on the symbol alone.
- R5: LANG_AT_LEAST: bit j is 1 exactly when at least j+1 symbols of value 1 have been consumed since reset.
- R6: A cycle with `sym_valid_i`=0 changes neither `state_o` nor `accept_o`, whatever value `sym_i` has.
- R7: LANG_RUN_ONES and LANG_RUN_ZEROS: bit j is 1 exactly when the last j+1 valid symbols all equal 1 (or 0, respectively). The opposite symbol clears every bit.
- R8: LANG_ALT_SUBSEQ: stage j waits for symbol value j mod 2. Bit j is 1 once pattern elements 0..j have occurred in order as a subsequence, counted from the progress given by `INIT`. Bits never fall.
- R9: `accept_o` is combinational from `state_o`: ACC_TOP gives bit NUM_FF-1, ACC_ANY gives the OR of all bits, and ACC_NOT_TOP gives the inverse of bit NUM_FF-1.
- R10: After NUM_FF consecutive valid symbols of the same value, further copies of that symbol leave `state_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, loads INIT |
| sym_valid_i | input | 1 | Consume `sym_i` on this edge |
| sym_i | input | 1 | Input symbol, 0 or 1 |
| state_o | output | NUM_FF | Flip-flop states, bit j is stage j |
| accept_o | output | 1 | State vector is in the accepting set |

## Verification
Some behaviour is checked by the assertions on every cycle:
- the set and clear terms are never active together;
- each stage follows its set, clear or hold command;
- a stalled cycle freezes the state;
- a stage rises only above a stage that was already set;
- stages of the sticky languages never fall.

Other behaviour only the bench's scenarios can show, because it depends on the whole symbol history: that the state vector encodes the right language, that the accept decode is correct, and that the state settles under a constant input. To cover this, the bench replays every binary string up to length eight from reset through four configurations, with stall cycles carrying a flipped symbol.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

  typedef enum logic [1:0] {
    LANG_AT_LEAST   = 2'd0,
    LANG_RUN_ONES   = 2'd1,
    LANG_RUN_ZEROS  = 2'd2,
    LANG_ALT_SUBSEQ = 2'd3
  } lang_e;

  typedef enum logic [1:0] {
    ACC_TOP     = 2'd0,
    ACC_ANY     = 2'd1,
    ACC_NOT_TOP = 2'd2
  } acc_e;

  typedef struct packed {
    logic set;
    logic clr;
  } sr_cmd_t;

endpackage

// File: rtl/rsr_rule.sv
module rsr_rule
  import rsr_pkg::*;
#(
  parameter lang_e LANG  = LANG_AT_LEAST,
  parameter int    STAGE = 0
) (
  input  logic    sym_i,
  input  logic    prev_i,   // pre-edge state of stage STAGE-1, 1 for stage 0
  output sr_cmd_t cmd_o
);

  localparam logic WANT = logic'(STAGE % 2);

  always_comb begin
    cmd_o = '0;
    case (LANG)
      LANG_AT_LEAST: begin
        cmd_o.set = sym_i & prev_i;
        cmd_o.clr = 1'b0;
      end
      LANG_RUN_ONES: begin
        cmd_o.set = sym_i & prev_i;
        cmd_o.clr = ~sym_i;
      end
      LANG_RUN_ZEROS: begin
        cmd_o.set = ~sym_i & prev_i;
        cmd_o.clr = sym_i;
      end
      LANG_ALT_SUBSEQ: begin
        cmd_o.set = (sym_i == WANT) & prev_i;
        cmd_o.clr = 1'b0;
      end
      default: cmd_o = '0;
    endcase
  end

endmodule

// File: rtl/rsr_cell.sv
module rsr_cell
  import rsr_pkg::*;
#(
  parameter logic INIT = 1'b0
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  sr_cmd_t cmd_i,
  output logic    q_o
);

  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_q <= INIT;
    else if (en_i) begin
      if (cmd_i.set)      q_q <= 1'b1;
      else if (cmd_i.clr) q_q <= 1'b0;
    end
  end

  assign q_o = q_q;

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> !(cmd_i.set && cmd_i.clr));

  a_r2_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cmd_i.set) |=> q_o);

  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cmd_i.clr) |=> !q_o);

  a_r2_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !cmd_i.set && !cmd_i.clr) |=> $stable(q_o));

  a_r6_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));

endmodule

// File: rtl/rsr_accept.sv
module rsr_accept
  import rsr_pkg::*;
#(
  parameter int   NUM_FF = 3,
  parameter acc_e ACC    = ACC_TOP
) (
  input  logic [NUM_FF-1:0] state_i,
  output logic              acc_o
);

  localparam int TOP = NUM_FF - 1;

  always_comb begin
    case (ACC)
      ACC_TOP:     acc_o = state_i[TOP];
      ACC_ANY:     acc_o = |state_i;
      ACC_NOT_TOP: acc_o = ~state_i[TOP];
      default:     acc_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/rsr_recognizer.sv
module rsr_recognizer
  import rsr_pkg::*;
#(
  parameter int                NUM_FF = 3,
  parameter lang_e             LANG   = LANG_AT_LEAST,
  parameter acc_e              ACC    = ACC_TOP,
  parameter logic [NUM_FF-1:0] INIT   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_valid_i,
  input  logic              sym_i,
  output logic [NUM_FF-1:0] state_o,
  output logic              accept_o
);

  localparam bit STICKY = (LANG == LANG_AT_LEAST) || (LANG == LANG_ALT_SUBSEQ);

  logic [NUM_FF-1:0] state_q;

  for (genvar k = 0; k < NUM_FF; k++) begin : g_stage
    logic    prev;
    sr_cmd_t cmd;

    if (k == 0) begin : g_base
      assign prev = 1'b1;
    end else begin : g_chain
      assign prev = state_q[k-1];

      // R4: a stage rises only above a stage that was already set
      a_r4_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state_q[k]) |-> $past(state_q[k-1]));
    end

    rsr_rule #(
      .LANG  (LANG),
      .STAGE (k)
    ) u_rule (
      .sym_i  (sym_i),
      .prev_i (prev),
      .cmd_o  (cmd)
    );

    rsr_cell #(
      .INIT (INIT[k])
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (sym_valid_i),
      .cmd_i  (cmd),
      .q_o    (state_q[k])
    );

    if (STICKY) begin : g_sticky
      // R5 and R8: the sticky languages never drop a stage
      a_r8_no_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(state_q[k]));
    end
  end

  rsr_accept #(
    .NUM_FF (NUM_FF),
    .ACC    (ACC)
  ) u_accept (
    .state_i (state_q),
    .acc_o   (accept_o)
  );

  assign state_o = state_q;

endmodule

// File: tb/rsr_recognizer_tb.sv
`timescale 1ns/1ps
module rsr_recognizer_tb_top;
  import rsr_pkg::*;

  localparam int K = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic sym = 1'b0;
  logic [K-1:0] st0, st1, st2, st3;
  logic ac0, ac1, ac2, ac3;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int ones, run1, run0, prog;

  always #10 clk = ~clk;

  rsr_recognizer #(.NUM_FF(K), .LANG(LANG_AT_LEAST), .ACC(ACC_TOP), .INIT(3'b000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_i(sym),
    .state_o(st0), .accept_o(ac0));
  rsr_recognizer #(.NUM_FF(K), .LANG(LANG_RUN_ONES), .ACC(ACC_ANY), .INIT(3'b000)) dut_run_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_i(sym),
    .state_o(st1), .accept_o(ac1));
  rsr_recognizer #(.NUM_FF(K), .LANG(LANG_RUN_ZEROS), .ACC(ACC_NOT_TOP), .INIT(3'b000)) dut_zero_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_i(sym),
    .state_o(st2), .accept_o(ac2));
  rsr_recognizer #(.NUM_FF(K), .LANG(LANG_ALT_SUBSEQ), .ACC(ACC_TOP), .INIT(3'b001)) dut_alt_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_i(sym),
    .state_o(st3), .accept_o(ac3));

  function automatic logic [K-1:0] therm(input int n);
    if (n >= K) return '1;
    return K'((1 << n) - 1);
  endfunction

  task automatic check(input string tag, input logic [K-1:0] got, input logic [K-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(input string why);
    check({why, " R5 at-least state"}, st0, therm(ones));
    check({why, " R7 run-ones state"}, st1, therm(run1));
    check({why, " R7 run-zeros state"}, st2, therm(run0));
    check({why, " R8 alt-subseq state"}, st3, therm(prog));
    check({why, " R9 accept top"}, K'(ac0), K'(ones >= K));
    check({why, " R9 accept any"}, K'(ac1), K'(run1 >= 1));
    check({why, " R9 accept not-top"}, K'(ac2), K'(run0 < K));
    check({why, " R9 accept top alt"}, K'(ac3), K'(prog >= K));
  endtask

  task automatic feed(input logic v, input logic s);
    sym_valid = v;
    sym = s;
    @(negedge clk);
  endtask

  task automatic ref_step(input logic s);
    if (s) begin ones++; run1++; run0 = 0; end
    else   begin run0++; run1 = 0; end
    if (prog < K && s == logic'(prog % 2)) prog++;
  endtask

  task automatic do_reset();
    sym_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    ones = 0; run1 = 0; run0 = 0; prog = 1;
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [K-1:0] snap0, snap1, snap2, snap3;
    @(negedge clk);
    do_reset();
    check_all("R1 after release");

    // R4: a single 1 sets only the base stage
    feed(1'b1, 1'b1); ref_step(1'b1);
    check("R4 only stage 0 rises", st0, 3'b001);
    // R2/R3: clear term wins on a 0 for the run-ones machine
    feed(1'b1, 1'b1); ref_step(1'b1);
    check("R2 run-ones set", st1, 3'b011);
    feed(1'b1, 1'b0); ref_step(1'b0);
    check("R2 R3 run-ones cleared", st1, 3'b000);
    check_all("R2 mixed");

    // exhaustive sweep of all strings up to length 8
    for (int len = 0; len <= 8; len++) begin
      for (int code = 0; code < (1 << len); code++) begin
        do_reset();
        for (int pos = 0; pos < len; pos++) begin
          logic s;
          s = code[pos];
          if ((pos + code) % 3 == 0) begin
            feed(1'b0, ~s);
            check_all("R6 stall");
          end
          feed(1'b1, s);
          ref_step(s);
          check_all("sweep");
        end
      end
    end

    // R10: constant input settles after K symbols
    for (int v = 0; v < 2; v++) begin
      do_reset();
      for (int i = 0; i < K; i++) feed(1'b1, logic'(v));
      snap0 = st0; snap1 = st1; snap2 = st2; snap3 = st3;
      feed(1'b1, logic'(v));
      feed(1'b1, logic'(v));
      check("R10 at-least settled", st0, snap0);
      check("R10 run-ones settled", st1, snap1);
      check("R10 run-zeros settled", st2, snap2);
      check("R10 alt settled", st3, snap3);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule